// File: doc/BRIEF.md
# Pulsed Overload Protection Sequencer

This block decides whether the power stage of a supply output may conduct. It watches two comparator inputs that are already synchronised to the clock. The first reports an output overload. The second reports an over-temperature condition, with its own hysteresis. From these it drives an output-enable line and two diagnostic flags that a status register can read: `olf_o` for overload and `otf_o` for over-temperature.

A mode input selects how overload is handled.

- **Dynamic mode** (`pcl_i` = 0): an overload shuts the output off for a long rest period. The output is then allowed back for a short trial window whose length is one tenth of the rest period, using integer division. The output returns to normal only when a whole trial window has passed with no overload seen. Otherwise it goes back to rest.
- **Static mode** (`pcl_i` = 1): the output is never cut by this block, and the flag simply mirrors the overload input.

Time is counted in ticks. A tick comes either from an input pin or from an internal clock divider, chosen by parameter. The main enable input `en_i` forces the output off and returns the sequencer to its idle state.

Top module: `ovp_seq`

## Requirements
- R1: After reset, with `en_i` = 1, `pcl_i` = 0 and no overload, `out_en_o` = 1 and `olf_o` = 0. While `rst_n` is low, `olf_o` = 0 and `otf_o` = 0.
- R2: In dynamic mode, an overload sampled during normal operation sets `olf_o` = 1 and drops `out_en_o` to 0 after that same clock edge.
- R3: The rest period lasts exactly `TOFF_TICKS` ticks. Overload seen during the rest period neither shortens nor extends it. Clocks without a tick do not advance it.
- R4: After the rest period, `out_en_o` returns to 1 for a trial window of `TOFF_TICKS/10` ticks, and `olf_o` stays 1 during that window.
- R5: If overload is sampled at any tick-clock of the trial window, including a window whose final sample is clean, the sequencer returns to a new rest period (`out_en_o` = 0, `olf_o` = 1).
- R6: After a trial window with no overload sampled, normal operation resumes and `olf_o` clears to 0 on the clock that closes the window.
- R7: In static mode, `out_en_o` stays 1 whatever the overload input does, and `olf_o` equals the overload input sampled at the previous clock edge. Selecting static mode during a rest period ends that period on the next clock.
- R8: Switching from static to dynamic mode while overload is present starts a rest period on the next clock.
- R9: `en_i` = 0 forces `out_en_o` to 0, clears `olf_o` on the next clock, and returns the sequencer to idle, so that re-enabling without overload gives `out_en_o` = 1 at once.
- R10: `otf_o` equals the over-temperature input sampled at the previous clock edge. While `otf_o` = 1, `out_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Main enable for the power stage |
| pcl_i | input | 1 | Protection mode: 0 dynamic, 1 static |
| ovl_i | input | 1 | Synchronised overload comparator |
| hot_i | input | 1 | Synchronised over-temperature comparator, with hysteresis |
| tick_i | input | 1 | Time-base tick (used when `EXT_TICK` = 1) |
| out_en_o | output | 1 | Enable for the power stage |
| olf_o | output | 1 | Overload diagnostic flag |
| otf_o | output | 1 | Over-temperature diagnostic flag |

## Verification
The assertions check, on every cycle, the local relations:

- the flag rises together with the output being disabled in dynamic mode;
- the flag falls only after a clean sample;
- static mode mirrors the overload input;
- enable-low clears the flag;
- the thermal flag tracks its input and blocks the output.

Only the bench scenarios can show the long-range timing. That covers the exact rest and trial lengths, the effect of a missing tick, and a dirty trial window whose last sample is clean. It also covers a rest period aborted by a mode change and the recovery after enable is toggled.

// File: rtl/ovp_seq.sv
module ovp_seq #(
  parameter int TOFF_TICKS = 30,
  parameter bit EXT_TICK   = 1'b1,
  parameter int DIV_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pcl_i,
  input  logic ovl_i,
  input  logic hot_i,
  input  logic tick_i,
  output logic out_en_o,
  output logic olf_o,
  output logic otf_o
);
  localparam int TON_TICKS = (TOFF_TICKS / 10 < 1) ? 1 : TOFF_TICKS / 10;
  localparam int CW        = $clog2(TOFF_TICKS + 1);
  localparam int DW        = $clog2(DIV_CYCLES + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(TOFF_TICKS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(TON_TICKS - 1);

  typedef enum logic [1:0] {S_RUN, S_OFF, S_TRY} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dirty;
  logic          tick;

  generate
    if (EXT_TICK) begin : g_ext
      assign tick = tick_i;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                               div_q <= '0;
        else if (div_q == DW'(DIV_CYCLES - 1))    div_q <= '0;
        else                                      div_q <= div_q + 1'b1;
      assign tick = (div_q == DW'(DIV_CYCLES - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RUN;
      cnt   <= '0;
      dirty <= 1'b0;
      olf_o <= 1'b0;
    end else if (!en_i) begin
      st    <= S_RUN;
      cnt   <= '0;
      dirty <= 1'b0;
      olf_o <= 1'b0;
    end else if (pcl_i) begin
      st    <= S_RUN;
      cnt   <= '0;
      dirty <= 1'b0;
      olf_o <= ovl_i;
    end else begin
      unique case (st)
        S_RUN: begin
          olf_o <= ovl_i;
          cnt   <= '0;
          if (ovl_i) st <= S_OFF;
        end
        S_OFF: if (tick) begin
          if (cnt == OFF_LAST) begin
            st    <= S_TRY;
            cnt   <= '0;
            dirty <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TRY: if (tick) begin
          if (cnt == ON_LAST) begin
            cnt <= '0;
            if (dirty || ovl_i) begin
              st <= S_OFF;
            end else begin
              st    <= S_RUN;
              olf_o <= 1'b0;
            end
            dirty <= 1'b0;
          end else begin
            cnt   <= cnt + 1'b1;
            dirty <= dirty | ovl_i;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) otf_o <= 1'b0;
    else        otf_o <= hot_i;

  assign out_en_o = en_i & ~otf_o & (st != S_OFF);
endmodule

module ovp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic pcl_i,
  input logic ovl_i,
  input logic hot_i,
  input logic out_en_o,
  input logic olf_o,
  input logic otf_o
);
  a_r2_dyn_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !pcl_i && ovl_i) |=> olf_o);

  a_r2_rise_cuts_output: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(olf_o) && !$past(pcl_i)) |-> !out_en_o);

  a_r6_clear_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(olf_o) && $past(en_i)) |-> !$past(ovl_i));

  a_r7_static_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pcl_i) |=> (olf_o == $past(ovl_i)));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !olf_o);

  a_r10_temp_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (otf_o == $past(hot_i)));

  a_r10_temp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    otf_o |-> !out_en_o);
endmodule

bind ovp_seq ovp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .pcl_i(pcl_i), .ovl_i(ovl_i),
  .hot_i(hot_i), .out_en_o(out_en_o), .olf_o(olf_o), .otf_o(otf_o)
);

// File: tb/ovp_seq_tb.sv
module ovp_seq_tb_top;
  localparam int TOFF = 30;
  localparam int TON  = TOFF / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, pcl = 0, ovl = 0, hot = 0, tick = 1;
  logic out_en, olf, otf;
  int total = 0, bad = 0;

  typedef struct { logic e_out; logic e_olf; logic e_otf; string req; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ovp_seq #(.TOFF_TICKS(TOFF), .EXT_TICK(1'b1), .DIV_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pcl_i(pcl), .ovl_i(ovl),
    .hot_i(hot), .tick_i(tick), .out_en_o(out_en), .olf_o(olf), .otf_o(otf));

  task automatic cyc(input logic e, input logic p, input logic o, input logic h,
                     input logic t, input logic x_out, input logic x_olf,
                     input logic x_otf, input string r);
    exp_t it;
    @(negedge clk);
    en = e; pcl = p; ovl = o; hot = h; tick = t;
    it.e_out = x_out; it.e_olf = x_olf; it.e_otf = x_otf; it.req = r;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        total++;
        if (out_en !== it.e_out || olf !== it.e_olf || otf !== it.e_otf) begin
          bad++;
          $display("FAIL %s: got out=%b olf=%b otf=%b exp out=%b olf=%b otf=%b",
                   it.req, out_en, olf, otf, it.e_out, it.e_olf, it.e_otf);
        end
      end
    end
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin : driver
    en = 0; hot = 1; ovl = 1;
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (out_en !== 0 || olf !== 0 || otf !== 0) begin
      bad++;
      $display("FAIL R1 reset: got out=%b olf=%b otf=%b exp 000", out_en, olf, otf);
    end
    @(negedge clk);
    hot = 0; ovl = 0;
    rst_n = 1;

    // R1: normal operation
    cyc(1,0,0,0,1, 1,0,0, "R1");
    cyc(1,0,0,0,1, 1,0,0, "R1");

    // R2..R6: single overload, ignored overload during rest, clean trial
    cyc(1,0,1,0,1, 0,1,0, "R2");
    for (int i = 1; i < TOFF; i++) cyc(1,0,(i%3==0),0,1, 0,1,0, "R3");
    cyc(1,0,0,0,1, 1,1,0, "R4");
    for (int i = 1; i < TON; i++) cyc(1,0,0,0,1, 1,1,0, "R4");
    cyc(1,0,0,0,1, 1,0,0, "R6");
    cyc(1,0,0,0,1, 1,0,0, "R6");

    // R5: overload early in trial, clean last sample -> rest again
    cyc(1,0,1,0,1, 0,1,0, "R2");
    for (int i = 1; i < TOFF; i++) cyc(1,0,0,0,1, 0,1,0, "R3");
    cyc(1,0,0,0,1, 1,1,0, "R4");
    cyc(1,0,1,0,1, 1,1,0, "R5");
    for (int i = 2; i < TON; i++) cyc(1,0,0,0,1, 1,1,0, "R5");
    cyc(1,0,0,0,1, 0,1,0, "R5");
    // R3: missing ticks stretch the rest period
    for (int i = 1; i < TOFF; i++) cyc(1,0,0,0,1, 0,1,0, "R3");
    for (int i = 0; i < 5; i++) cyc(1,0,0,0,0, 0,1,0, "R3");
    cyc(1,0,0,0,1, 1,1,0, "R4");
    for (int i = 1; i < TON; i++) cyc(1,0,0,0,1, 1,1,0, "R4");
    cyc(1,0,0,0,1, 1,0,0, "R6");

    // R7: static mode mirrors overload, output stays on
    cyc(1,1,1,0,1, 1,1,0, "R7");
    cyc(1,1,1,0,1, 1,1,0, "R7");
    cyc(1,1,0,0,1, 1,0,0, "R7");
    cyc(1,1,1,0,1, 1,1,0, "R7");
    // R8: to dynamic with overload present
    cyc(1,0,1,0,1, 0,1,0, "R8");
    cyc(1,0,0,0,1, 0,1,0, "R8");
    // R7: static during rest ends it
    cyc(1,1,0,0,1, 1,0,0, "R7");
    cyc(1,0,0,0,1, 1,0,0, "R7");

    // R9: disable during rest
    cyc(1,0,1,0,1, 0,1,0, "R2");
    cyc(0,0,1,0,1, 0,0,0, "R9");
    cyc(0,0,0,0,1, 0,0,0, "R9");
    cyc(1,0,0,0,1, 1,0,0, "R9");

    // R10: over-temperature
    cyc(1,0,0,1,1, 0,0,1, "R10");
    cyc(1,0,0,1,1, 0,0,1, "R10");
    cyc(1,0,0,0,1, 1,0,0, "R10");
    cyc(1,1,1,1,1, 0,1,1, "R10");
    cyc(1,1,0,0,1, 1,0,0, "R10");

    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule